// File: doc/BRIEF.md
# Display Register Front End with Concealed Colour-Mode Unlock

This block sits between a simple byte-wide synchronous bus and a display controller. It turns a small set of port offsets into three indexed register banks: sequencer, CRT timing and graphics. Software first writes an index to a bank's index port. Its later data-port accesses then reach the register that the index selects. The contents of every bank are driven out as flat vectors, so downstream timing and pixel logic can use them with no further decoding.

The same front end holds the pixel mask of the colour converter, which is one byte at its own offset. It also holds a colour-mode register that has no address of its own. A run of four reads of the mask port, with no other access in between, arms a one-shot redirect. The next write to the mask port then lands in the colour-mode register, and the mask keeps its value. Drivers use these codes in that register: 0x00 for 8-bit indexed pixels, 0xC1 for 16-bit 5-6-5 pixels, and 0xC5 for 24- and 32-bit direct colour.

Top module: `vid_regport`

## Requirements
- R1: After reset, every bank register, every index register, the colour-mode register and bus_rdata are zero, and the pixel mask is 0xFF.
- R2: Offset 0x04 is the sequencer index and 0x05 its data port. A data write updates byte N of seq_regs, where N is the current index, in the cycle after the strobe.
- R3: Offset 0x14 is the CRT index and 0x15 its data port. A data write updates byte N of crt_regs in the cycle after the strobe.
- R4: Offset 0x0E is the graphics index and 0x0F its data port. A data write updates byte N of gfx_regs. A read of 0x0F returns 0x00.
- R5: Reads of the three index offsets return the last index written. Every read result appears on bus_rdata in the cycle after the read strobe.
- R6: A read of the sequencer or CRT data port returns the register that the current index selects.
- R7: When the index is not below the bank depth, a data write changes nothing and a data read returns 0x00.
- R8: Offset 0x06 is the pixel mask. A write there updates pix_mask unless the redirect is armed. A read returns pix_mask while the redirect is not armed.
- R9: Four consecutive reads of 0x06 arm the redirect. The next write to 0x06 goes to color_mode, leaves pix_mask unchanged and disarms the redirect.
- R10: A read of 0x06 while armed returns color_mode and leaves the redirect armed.
- R11: Any read or write of an offset other than 0x06 resets the read run, so later mask writes reach pix_mask.
- R12: A read of an unmapped offset returns 0x00. A write to one changes no register.
- R13: When bus_wr and bus_rd are both high, the cycle is a write only, and bus_rdata is 0x00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_addr | input | ADDR_W | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| seq_regs | output | SEQ_REGS*8 | Sequencer bank, byte N is register N |
| crt_regs | output | CRT_REGS*8 | CRT bank, byte N is register N |
| gfx_regs | output | GFX_REGS*8 | Graphics bank, byte N is register N |
| pix_mask | output | 8 | Pixel mask |
| color_mode | output | 8 | Concealed colour-mode register |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is registered at that same edge, so every result is due exactly one cycle after the stimulus. The bench drives a strobe for one cycle, starting on a falling edge. It samples bus_rdata and the flat outputs on the next falling edge, which falls between the capturing edge and the following one. Read sequences for the unlock are issued back to back, so the count of consecutive reads is exactly what the stimulus table states.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  // Port offsets decoded by the front end
  localparam int unsigned OFS_SEQ_IX  = 'h04;
  localparam int unsigned OFS_SEQ_DT  = 'h05;
  localparam int unsigned OFS_DAC_MSK = 'h06;
  localparam int unsigned OFS_GFX_IX  = 'h0E;
  localparam int unsigned OFS_GFX_DT  = 'h0F;
  localparam int unsigned OFS_CRT_IX  = 'h14;
  localparam int unsigned OFS_CRT_DT  = 'h15;

  localparam logic [7:0] MASK_RESET = 8'hFF;

  // Colour-mode codes written through the concealed path
  localparam logic [7:0] CMODE_IDX8  = 8'h00;
  localparam logic [7:0] CMODE_RGB16 = 8'hC1;
  localparam logic [7:0] CMODE_RGB24 = 8'hC5;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int unsigned DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               dat_we,
  input  logic [7:0]         wdata,
  output logic [7:0]         idx_q,
  output logic [7:0]         rd_byte,
  output logic [DEPTH*8-1:0] regs_flat
);
  localparam int unsigned SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    idx_d;
  logic          in_range;
  logic [SW-1:0] slot;

  assign in_range = (32'(idx_q) < DEPTH);
  assign slot     = idx_q[SW-1:0];

  always_comb idx_d = idx_we ? wdata : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [7:0] ent_q, ent_d;
    logic       ent_en;
    assign ent_en = dat_we && in_range && (slot == SW'(i));
    always_comb ent_d = ent_en ? wdata : ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end
    assign regs_flat[i*8 +: 8] = ent_q;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (in_range && (slot == SW'(i))) rd_byte = regs_flat[i*8 +: 8];
    end
  end

  // R5: an index write is captured for the next access
  assert_idx_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (idx_q == $past(wdata)));

  // R7: a data write with an index past the bank leaves every entry alone
  assert_range_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !in_range) |=> $stable(regs_flat));
endmodule

// File: rtl/vrf_dac.sv
module vrf_dac #(
  parameter int unsigned UNLOCK_READS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  input  logic       wr_hit,
  input  logic       other_acc,
  input  logic [7:0] wdata,
  output logic [7:0] mask_q,
  output logic [7:0] mode_q,
  output logic [7:0] rd_byte
);
  import vrf_pkg::*;

  localparam int unsigned CW = $clog2(UNLOCK_READS + 1);
  localparam logic [CW-1:0] ARM_CNT = CW'(UNLOCK_READS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    mask_d, mode_d;
  logic          armed;

  assign armed   = (cnt_q == ARM_CNT);
  assign rd_byte = armed ? mode_q : mask_q;

  always_comb begin
    cnt_d  = cnt_q;
    mask_d = mask_q;
    mode_d = mode_q;
    if (wr_hit) begin
      cnt_d = '0;
      if (armed) mode_d = wdata;
      else       mask_d = wdata;
    end else if (rd_hit) begin
      if (!armed) cnt_d = cnt_q + 1'b1;
    end else if (other_acc) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= MASK_RESET;
      mode_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ARM_CNT);

  assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !armed);

  assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_hit) |=> $stable(mask_q));

  assert_stay_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_hit && !wr_hit) |=> armed);

  assert_run_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    other_acc |=> (cnt_q == '0));
endmodule

// File: rtl/vid_regport.sv
module vid_regport #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned SEQ_REGS     = 8,
  parameter int unsigned CRT_REGS     = 32,
  parameter int unsigned GFX_REGS     = 16,
  parameter int unsigned UNLOCK_READS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic [SEQ_REGS*8-1:0] seq_regs,
  output logic [CRT_REGS*8-1:0] crt_regs,
  output logic [GFX_REGS*8-1:0] gfx_regs,
  output logic [7:0]            pix_mask,
  output logic [7:0]            color_mode
);
  import vrf_pkg::*;

  logic wr_fire, rd_fire, any_acc;
  logic hit_seq_ix, hit_seq_dt, hit_crt_ix, hit_crt_dt;
  logic hit_gfx_ix, hit_gfx_dt, hit_dac, unmapped;
  logic [7:0] seq_idx, crt_idx, gfx_idx;
  logic [7:0] seq_rd, crt_rd, gfx_rd, dac_rd;
  logic [7:0] rdata_d;

  // R13: a write strobe masks a simultaneous read strobe
  assign wr_fire = bus_wr;
  assign rd_fire = bus_rd && !bus_wr;
  assign any_acc = wr_fire || rd_fire;

  assign hit_seq_ix = (bus_addr == ADDR_W'(OFS_SEQ_IX));
  assign hit_seq_dt = (bus_addr == ADDR_W'(OFS_SEQ_DT));
  assign hit_crt_ix = (bus_addr == ADDR_W'(OFS_CRT_IX));
  assign hit_crt_dt = (bus_addr == ADDR_W'(OFS_CRT_DT));
  assign hit_gfx_ix = (bus_addr == ADDR_W'(OFS_GFX_IX));
  assign hit_gfx_dt = (bus_addr == ADDR_W'(OFS_GFX_DT));
  assign hit_dac    = (bus_addr == ADDR_W'(OFS_DAC_MSK));
  assign unmapped   = !(hit_seq_ix || hit_seq_dt || hit_crt_ix || hit_crt_dt ||
                        hit_gfx_ix || hit_gfx_dt || hit_dac);

  vrf_bank #(.DEPTH(SEQ_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .idx_we(wr_fire && hit_seq_ix), .dat_we(wr_fire && hit_seq_dt),
    .wdata(bus_wdata), .idx_q(seq_idx), .rd_byte(seq_rd), .regs_flat(seq_regs));

  vrf_bank #(.DEPTH(CRT_REGS)) u_crt (
    .clk(clk), .rst_n(rst_n),
    .idx_we(wr_fire && hit_crt_ix), .dat_we(wr_fire && hit_crt_dt),
    .wdata(bus_wdata), .idx_q(crt_idx), .rd_byte(crt_rd), .regs_flat(crt_regs));

  vrf_bank #(.DEPTH(GFX_REGS)) u_gfx (
    .clk(clk), .rst_n(rst_n),
    .idx_we(wr_fire && hit_gfx_ix), .dat_we(wr_fire && hit_gfx_dt),
    .wdata(bus_wdata), .idx_q(gfx_idx), .rd_byte(gfx_rd), .regs_flat(gfx_regs));

  vrf_dac #(.UNLOCK_READS(UNLOCK_READS)) u_dac (
    .clk(clk), .rst_n(rst_n),
    .rd_hit(rd_fire && hit_dac), .wr_hit(wr_fire && hit_dac),
    .other_acc(any_acc && !hit_dac), .wdata(bus_wdata),
    .mask_q(pix_mask), .mode_q(color_mode), .rd_byte(dac_rd));

  // Graphics data is write-only; its read value is discarded here
  logic gfx_rd_unused;
  assign gfx_rd_unused = ^gfx_rd;

  always_comb begin
    rdata_d = '0;
    if (rd_fire) begin
      unique case (1'b1)
        hit_seq_ix: rdata_d = seq_idx;
        hit_seq_dt: rdata_d = seq_rd;
        hit_crt_ix: rdata_d = crt_idx;
        hit_crt_dt: rdata_d = crt_rd;
        hit_gfx_ix: rdata_d = gfx_idx;
        hit_dac:    rdata_d = dac_rd;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && unmapped) |=> (bus_rdata == '0));

  assert_gfx_wo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && hit_gfx_dt) |=> (bus_rdata == '0));

  assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (bus_rdata == '0));

  assert_unmapped_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && unmapped) |=> ($stable(seq_regs) && $stable(crt_regs) &&
                               $stable(gfx_regs) && $stable(pix_mask) &&
                               $stable(color_mode)));
endmodule

// File: tb/vid_regport_test.sv
module vid_regport_test;
  logic clk, rst_n, bus_wr, bus_rd;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [63:0]  seq_regs;
  logic [255:0] crt_regs;
  logic [127:0] gfx_regs;
  logic [7:0] pix_mask, color_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vid_regport uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_regs(seq_regs), .crt_regs(crt_regs), .gfx_regs(gfx_regs),
    .pix_mask(pix_mask), .color_mode(color_mode));

  initial clk = 0;
  always #5 clk = ~clk;

  // Vector: {req[3:0], is_read, addr[7:0], data[7:0], expected[7:0]}
  localparam int NV = 32;
  localparam logic [28:0] VEC [NV] = '{
    {4'd5,  1'b1, 8'h04, 8'h00, 8'h00}, // R5 seq index after reset
    {4'd2,  1'b0, 8'h04, 8'h02, 8'h00}, // R2
    {4'd2,  1'b0, 8'h05, 8'h5A, 8'h00}, // R2
    {4'd5,  1'b1, 8'h04, 8'h00, 8'h02}, // R5
    {4'd6,  1'b1, 8'h05, 8'h00, 8'h5A}, // R6
    {4'd3,  1'b0, 8'h14, 8'h1D, 8'h00}, // R3
    {4'd3,  1'b0, 8'h15, 8'h80, 8'h00}, // R3
    {4'd6,  1'b1, 8'h15, 8'h00, 8'h80}, // R6
    {4'd7,  1'b0, 8'h14, 8'h40, 8'h00}, // R7 index past the bank
    {4'd7,  1'b0, 8'h15, 8'h77, 8'h00}, // R7
    {4'd7,  1'b1, 8'h15, 8'h00, 8'h00}, // R7
    {4'd5,  1'b1, 8'h14, 8'h00, 8'h40}, // R5
    {4'd4,  1'b0, 8'h0E, 8'h06, 8'h00}, // R4
    {4'd4,  1'b0, 8'h0F, 8'h01, 8'h00}, // R4
    {4'd4,  1'b1, 8'h0F, 8'h00, 8'h00}, // R4 write-only data
    {4'd4,  1'b1, 8'h0E, 8'h00, 8'h06}, // R4 index readback
    {4'd8,  1'b1, 8'h06, 8'h00, 8'hFF}, // R8 mask reset value
    {4'd8,  1'b0, 8'h06, 8'h3C, 8'h00}, // R8 plain mask write
    {4'd8,  1'b1, 8'h06, 8'h00, 8'h3C}, // R8 read 1
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // R9 read 2
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // R9 read 3
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // R9 read 4 arms
    {4'd10, 1'b1, 8'h06, 8'h00, 8'h00}, // R10 armed read gives mode
    {4'd9,  1'b0, 8'h06, 8'hC1, 8'h00}, // R9 redirected write
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // R9 mask kept, read 1
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // read 2
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // read 3
    {4'd9,  1'b1, 8'h06, 8'h00, 8'h3C}, // read 4 arms
    {4'd10, 1'b1, 8'h06, 8'h00, 8'hC1}, // R10
    {4'd11, 1'b1, 8'h04, 8'h00, 8'h02}, // R11 other access
    {4'd11, 1'b1, 8'h06, 8'h00, 8'h3C}, // R11 run restarted
    {4'd12, 1'b1, 8'h30, 8'h00, 8'h00}  // R12 unmapped read
  };

  task automatic bus_op(input logic w, input logic r, input logic [7:0] a,
                        input logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic check(input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0]  s_seq;
    logic [255:0] s_crt;
    logic [127:0] s_gfx;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 seq", 256'(seq_regs), 256'(0));
    check("R1 crt", crt_regs, 256'(0));
    check("R1 gfx", 256'(gfx_regs), 256'(0));
    check("R1 mask", 256'(pix_mask), 256'(8'hFF));
    check("R1 mode", 256'(color_mode), 256'(0));
    check("R1 rdata", 256'(bus_rdata), 256'(0));

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      bus_op(!v[24], v[24], v[23:16], v[15:8]);
      if (v[24]) begin
        checks++;
        if (bus_rdata !== v[7:0]) begin
          errors++;
          $display("FAIL R%0d vector %0d actual %0h expected %0h",
                   v[28:25], i, bus_rdata, v[7:0]);
        end
      end
    end

    // Flat outputs after the table
    check("R2 seq byte 2", 256'(seq_regs[23:16]), 256'(8'h5A));
    check("R3 crt byte 0x1D", 256'(crt_regs[239:232]), 256'(8'h80));
    check("R4 gfx byte 6", 256'(gfx_regs[55:48]), 256'(8'h01));
    check("R9 color_mode", 256'(color_mode), 256'(8'hC1));
    check("R9 pix_mask", 256'(pix_mask), 256'(8'h3C));

    // R12 unmapped write changes nothing; also breaks the read run (R11)
    s_seq = seq_regs; s_crt = crt_regs; s_gfx = gfx_regs;
    bus_op(1, 0, 8'h06, 8'h3C);     // clear run
    bus_op(0, 1, 8'h06, 8'h00);
    bus_op(0, 1, 8'h06, 8'h00);
    bus_op(0, 1, 8'h06, 8'h00);     // three reads
    bus_op(1, 0, 8'h30, 8'hEE);     // unmapped write
    check("R12 seq", 256'(seq_regs), 256'(s_seq));
    check("R12 crt", crt_regs, s_crt);
    check("R12 gfx", 256'(gfx_regs), 256'(s_gfx));
    bus_op(0, 1, 8'h06, 8'h00);     // run restarts at one
    bus_op(1, 0, 8'h06, 8'h55);
    check("R11 mask write", 256'(pix_mask), 256'(8'h55));
    check("R11 mode kept", 256'(color_mode), 256'(8'hC1));

    // R13 write and read together: write only
    bus_op(1, 1, 8'h05, 8'h11);
    check("R13 rdata", 256'(bus_rdata), 256'(0));
    check("R13 seq byte 2", 256'(seq_regs[23:16]), 256'(8'h11));

    // R9 third code through the concealed path
    for (int k = 0; k < 4; k++) bus_op(0, 1, 8'h06, 8'h00);
    bus_op(1, 0, 8'h06, 8'hC5);
    check("R9 mode 24/32", 256'(color_mode), 256'(8'hC5));
    check("R9 mask kept", 256'(pix_mask), 256'(8'h55));
    bus_op(0, 1, 8'h06, 8'h00);
    check("R9 disarmed", 256'(bus_rdata), 256'(8'h55));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule